// File: doc/BRIEF.md
# Operation Sampling Interval Selector

The block picks single operations out of an issue stream for profiling. Each eligible operation decrements an interval countdown. The operation that exhausts the countdown is chosen, and the countdown reloads in the same cycle. The reload value is the programmed interval, or a minimum fixed by a parameter when the programmed interval is zero. When jitter is enabled, a pseudo-random offset is added to each reload so the selection does not lock onto loop periods.

Only one chosen operation may be tracked at a time. A busy flag marks the sample in flight and is cleared by a completion strobe. A selection that lands while the tracker is busy is dropped and counted as a collision. Three saturating counters report eligible operations, accepted samples and collisions. Record capture, filtering and memory writes belong to other blocks.

Top module: `op_sample_picker`

## Requirements
- R1: After synchronous reset, `sample_pulse`, `busy` and all three counters are 0, the stored interval is 0 and the countdown holds `MIN_IVL`.
- R2: Each cycle with `op_valid` high (and `ivl_wr` low) decrements the countdown. The operation that finds the countdown at 1 is selected and the countdown reloads in that same cycle. An interval of N therefore selects every Nth eligible operation. An accepted selection raises `sample_pulse` for exactly one cycle, in the cycle after the operation.
- R3: When the stored interval is 0, the reload base is the parameter `MIN_IVL`. Otherwise the base is the stored interval.
- R4: A cycle with `ivl_wr` high stores `ivl_data` and loads the countdown at once from the new value. An operation in that same cycle does not decrement the countdown and cannot be selected.
- R5: With `jitter_en` high, every reload (a selection or a write) adds bits [7:0] of a 16-bit LFSR to the base. With `jitter_en` low, nothing is added. The LFSR starts at 16'hACE1, shifts left, and feeds bit15^bit13^bit12^bit10 into bit 0. It steps once on every reload, whether or not jitter is enabled, and the value it holds before that step is the one that is used.
- R6: `busy` rises in the cycle after an accepted selection and falls in the cycle after `smp_done` is high. `smp_done` while not busy has no effect.
- R7: A selection while busy (and `smp_done` low) is a collision. It produces no `sample_pulse`, leaves `busy` set, and increments `clash_count`. The countdown still reloads.
- R8: A selection in the same cycle as `smp_done` on a busy tracker is accepted: `sample_pulse` rises and `busy` stays high.
- R9: `pop_count` increments once for every cycle with `op_valid` high, including write cycles. `pick_count` increments for every accepted selection.
- R10: All three counters saturate at 2^CNT_W-1 and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One eligible operation issued this cycle |
| smp_done | input | 1 | The sampled operation in flight has completed |
| ivl_wr | input | 1 | Write strobe for the interval register |
| ivl_data | input | IVL_W | New interval value |
| jitter_en | input | 1 | Add the pseudo-random offset on reloads |
| sample_pulse | output | 1 | Registered one-cycle pulse: the operation was sampled |
| busy | output | 1 | A sampled operation is in flight |
| pop_count | output | CNT_W | Saturating count of eligible operations |
| pick_count | output | CNT_W | Saturating count of accepted samples |
| clash_count | output | CNT_W | Saturating count of collisions |

## Verification
Two functions can fall on the same clock edge: the countdown reaching its terminal value, and the completion strobe freeing the tracker. The bench provokes this by programming a short interval and raising `smp_done` exactly in the cycle of the next terminal operation. A correct design accepts that selection, keeps `busy` high and leaves the collision count unchanged (R8). The complementary case, a terminal operation with no completion pending, must be counted as a collision. A write landing on an operation cycle is also driven, to show that the write wins the countdown while the population counter still counts the operation.

// File: rtl/opsamp_pkg.sv
package opsamp_pkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
  localparam int JIT_W = 8;
  localparam int NUM_CNT = 3;

  // Maximal-length step: taps 16,14,13,11
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/opsamp_lfsr.sv
module opsamp_lfsr
  import opsamp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [JIT_W-1:0]  jit
);
  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= LFSR_SEED;
    else if (step) state_q <= lfsr_next(state_q);
  end

  assign jit = state_q[JIT_W-1:0];

  // A maximal-length register never reaches the all-zero lockup state
  AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (rst)
    step |=> state_q != '0); // R5
endmodule

// File: rtl/opsamp_countdown.sv
module opsamp_countdown
  import opsamp_pkg::*;
#(
  parameter int IVL_W   = 12,
  parameter int MIN_IVL = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic             ivl_wr,
  input  logic [IVL_W-1:0] ivl_data,
  input  logic             jitter_en,
  input  logic [JIT_W-1:0] jit,
  output logic             hit,
  output logic             reload
);
  localparam int REM_W = IVL_W + 1;

  logic [IVL_W-1:0] ivl_q;
  logic [REM_W-1:0] rem_q;
  logic [IVL_W-1:0] src_ivl;
  logic [REM_W-1:0] base;
  logic [REM_W-1:0] reload_val;

  always_comb begin
    src_ivl    = ivl_wr ? ivl_data : ivl_q;
    base       = (src_ivl == '0) ? REM_W'(MIN_IVL) : REM_W'(src_ivl);
    reload_val = base + (jitter_en ? REM_W'(jit) : '0);
  end

  assign hit    = op_valid && !ivl_wr && (rem_q == REM_W'(1));
  assign reload = ivl_wr || hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ivl_q <= '0;
      rem_q <= REM_W'(MIN_IVL);
    end else if (ivl_wr) begin
      ivl_q <= ivl_data;
      rem_q <= reload_val;
    end else if (op_valid) begin
      if (hit) rem_q <= reload_val;
      else     rem_q <= rem_q - REM_W'(1);
    end
  end

  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    op_valid && !ivl_wr && rem_q > REM_W'(1) |=> rem_q == $past(rem_q) - REM_W'(1)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !op_valid && !ivl_wr |=> $stable(rem_q)); // R2
  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
    ivl_wr |=> ivl_q == $past(ivl_data)); // R4
endmodule

// File: rtl/opsamp_tracker.sv
module opsamp_tracker (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic done,
  output logic accept,
  output logic clash,
  output logic busy_o,
  output logic pulse_o
);
  logic busy_q;
  logic pulse_q;
  logic free;

  assign free   = !busy_q || done;
  assign accept = sel && free;
  assign clash  = sel && !free;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      busy_q  <= (busy_q && !done) || accept;
      pulse_q <= accept;
    end
  end

  assign busy_o  = busy_q;
  assign pulse_o = pulse_q;

  AST_PULSE_BUSY: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> busy_q); // R6
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    busy_q && done && !sel |=> !busy_q); // R6
  AST_CLASH_DROPS: assert property (@(posedge clk) disable iff (rst)
    sel && busy_q && !done |=> !pulse_q && busy_q); // R7
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sel && busy_q && done |=> pulse_q && busy_q); // R8
endmodule

// File: rtl/opsamp_satcnt.sv
module opsamp_satcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (inc && cnt_q != TOP) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt_q == TOP |=> cnt_q == TOP); // R10
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    inc && cnt_q != TOP |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R9
endmodule

// File: rtl/op_sample_picker.sv
module op_sample_picker
  import opsamp_pkg::*;
#(
  parameter int IVL_W   = 12,
  parameter int MIN_IVL = 64,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic             smp_done,
  input  logic             ivl_wr,
  input  logic [IVL_W-1:0] ivl_data,
  input  logic             jitter_en,
  output logic             sample_pulse,
  output logic             busy,
  output logic [CNT_W-1:0] pop_count,
  output logic [CNT_W-1:0] pick_count,
  output logic [CNT_W-1:0] clash_count
);
  initial begin
    if (IVL_W < JIT_W) $error("IVL_W must be at least the jitter width");
    if (MIN_IVL < 1 || MIN_IVL >= (1 << IVL_W)) $error("MIN_IVL out of range");
  end

  logic [JIT_W-1:0] jit;
  logic hit, reload, accept, clash;
  logic [NUM_CNT-1:0] inc_vec;
  logic [CNT_W-1:0]   cnt_arr [NUM_CNT];

  opsamp_lfsr u_lfsr (
    .clk  (clk),
    .rst  (rst),
    .step (reload),
    .jit  (jit)
  );

  opsamp_countdown #(.IVL_W(IVL_W), .MIN_IVL(MIN_IVL)) u_cd (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .ivl_wr    (ivl_wr),
    .ivl_data  (ivl_data),
    .jitter_en (jitter_en),
    .jit       (jit),
    .hit       (hit),
    .reload    (reload)
  );

  opsamp_tracker u_trk (
    .clk     (clk),
    .rst     (rst),
    .sel     (hit),
    .done    (smp_done),
    .accept  (accept),
    .clash   (clash),
    .busy_o  (busy),
    .pulse_o (sample_pulse)
  );

  assign inc_vec = {clash, accept, op_valid};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    opsamp_satcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .inc (inc_vec[g]),
      .cnt (cnt_arr[g])
    );
  end

  assign pop_count   = cnt_arr[0];
  assign pick_count  = cnt_arr[1];
  assign clash_count = cnt_arr[2];

  AST_PULSE_COUNTED: assert property (@(posedge clk) disable iff (rst)
    sample_pulse && $past(pick_count) != '1 |-> pick_count != $past(pick_count)); // R9
endmodule

// File: tb/op_sample_picker_test.sv
module op_sample_picker_test;
  localparam int IVL_W = 12;
  localparam int MIN_IVL = 3;
  localparam int CNT_W = 8;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 0;
  logic rst = 1;
  logic op_valid = 0, smp_done = 0, ivl_wr = 0, jitter_en = 0;
  logic [IVL_W-1:0] ivl_data = '0;
  logic sample_pulse, busy;
  logic [CNT_W-1:0] pop_count, pick_count, clash_count;

  always #10 clk = ~clk;

  op_sample_picker #(.IVL_W(IVL_W), .MIN_IVL(MIN_IVL), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .smp_done(smp_done),
    .ivl_wr(ivl_wr), .ivl_data(ivl_data), .jitter_en(jitter_en),
    .sample_pulse(sample_pulse), .busy(busy), .pop_count(pop_count),
    .pick_count(pick_count), .clash_count(clash_count)
  );

  typedef struct {
    bit    samp;
    bit    bsy;
    int    pop;
    int    pick;
    int    clash;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  // Reference model state, built from the requirements
  int m_ivl = 0, m_rem = MIN_IVL, m_pop = 0, m_pick = 0, m_clash = 0;
  bit m_busy = 0, m_samp = 0, m_jen = 0;
  logic [15:0] m_lfsr = 16'hACE1;

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  function automatic int reload_of(input int ivl);
    int b;
    b = (ivl == 0) ? MIN_IVL : ivl;
    return b + (m_jen ? int'(m_lfsr[7:0]) : 0);
  endfunction

  task automatic step(input bit op, input bit dn, input bit wr, input int data, input string tag);
    bit sel, free;
    exp_t e;
    @(negedge clk);
    op_valid = op; smp_done = dn; ivl_wr = wr; ivl_data = data[IVL_W-1:0]; jitter_en = m_jen;
    @(posedge clk);
    sel = 0;
    m_pop = sat(m_pop + (op ? 1 : 0));
    if (wr) begin
      m_ivl = data;
      m_rem = reload_of(m_ivl);
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end else if (op) begin
      if (m_rem == 1) begin
        sel = 1;
        m_rem = reload_of(m_ivl);
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
      end else m_rem = m_rem - 1;
    end
    free = !m_busy || dn;
    m_samp = sel && free;
    if (sel && !free) m_clash = sat(m_clash + 1);
    if (m_samp) m_pick = sat(m_pick + 1);
    m_busy = (m_busy && !dn) || m_samp;
    e.samp = m_samp; e.bsy = m_busy; e.pop = m_pop; e.pick = m_pick; e.clash = m_clash; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic cmp(input int act, input int exp, input string what, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per cycle and compares at the port
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        cmp(int'(sample_pulse), int'(e.samp), "sample_pulse (R2)", e.tag);
        cmp(int'(busy), int'(e.bsy), "busy (R6)", e.tag);
        cmp(int'(pop_count), e.pop, "pop_count (R9)", e.tag);
        cmp(int'(pick_count), e.pick, "pick_count (R9)", e.tag);
        cmp(int'(clash_count), e.clash, "clash_count (R7)", e.tag);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: idle after reset
    step(0, 0, 0, 0, "R1 reset state");
    step(0, 0, 0, 0, "R1 reset state");
    // R3: unset interval falls back to MIN_IVL; R2 countdown
    for (int i = 0; i < 9; i++) step(1, 0, 0, 0, "R3 minimum interval");
    step(0, 1, 0, 0, "R6 completion");
    // R6: completion while idle is ignored
    step(0, 1, 0, 0, "R6 idle done ignored");
    step(0, 0, 0, 0, "R6 idle done ignored");
    // R4: write reloads at once; R2 with gaps in the stream
    step(0, 0, 1, 5, "R4 interval write");
    for (int i = 0; i < 16; i++) step(i % 3 != 2, i % 4 == 3, 0, 0, "R2 gapped stream");
    // R4: write wins over an operation in the same cycle
    step(1, 1, 1, 2, "R4 write with op");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R4 after write");
    step(0, 1, 0, 0, "R6 completion");
    // R7: collisions with nothing completing
    step(0, 0, 1, 2, "R7 setup");
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, "R7 collision");
    // R8: completion lands on the terminal operation
    for (int i = 0; i < 8; i++) step(1, i % 2 == 1, 0, 0, "R8 done on selection");
    step(0, 1, 0, 0, "R6 completion");
    // R5: jitter on each reload
    m_jen = 1;
    step(0, 0, 1, 1, "R5 jitter write");
    for (int i = 0; i < 600; i++) step(1, 1, 0, 0, "R5 jitter stream");
    m_jen = 0;
    // R10: drive collisions until the counter pins
    step(0, 0, 1, 1, "R10 setup");
    for (int i = 0; i < 300; i++) step(1, 0, 0, 0, "R10 saturation");
    step(0, 0, 0, 0, "R10 hold");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule